// File: doc/BRIEF.md
# Pointer-Banked Control Register File

This block is the host-facing control store of an eight-channel line interface. A 5-bit synchronous read/write bus reaches four separate register banks. The top address, 1Fh, holds an 8-bit bank selector. Its value decides which bank the other 31 addresses reach. Software that never touches the selector sees only the primary bank. That bank therefore behaves like a plain 22-register control file.

The per-channel bank also holds a sticky interrupt status register. Each bit is set by an event input from outside the block. A control bit chooses how software clears the status: by reading it (the default) or by writing ones to it. A single interrupt output is raised when any status bit is set and its enable bit is also set.

Top module: `banked_regfile`

## Requirements
- R1: After reset the selector is 00h, every storage register is 00h, `rdata` is 00h and `irq` is low.
- R2: Address 1Fh can always be written and read back, whatever value the selector holds, including values that select no bank.
- R3: Selector codes choose the bank: 00h primary, AAh secondary, 01h per-channel, 02h test. The same address in two banks names two independent registers.
- R4: In the primary bank, 00h–15h store and return written data. 16h–1Eh read 00h and ignore writes.
- R5: In the secondary bank, only 00h, 01h and 03h–06h store data. 02h and 07h–1Eh read 00h and ignore writes.
- R6: In the per-channel bank, 00h–07h, 10h, 11h, 13h–16h and 1Eh store data. 10h is the interrupt enable mask (bit n enables channel n), 12h is the status register, and bit 0 of 1Eh selects the clearing policy (0 = clear on read, 1 = clear on write). All other addresses read 00h and ignore writes.
- R7: In the test bank, only 00h, 02h–08h and 10h store data. The rest read 00h and ignore writes.
- R8: While the selector holds any value other than the four codes, addresses 00h–1Eh read 00h and writes to them change no register.
- R9: A high `evt[n]` sets status bit n. The bit then stays set until a clearing access under the active policy.
- R10: Under clear-on-read, a read of 12h returns the current status and then clears all of its bits. A write to 12h has no effect.
- R11: Under clear-on-write, writing 12h clears exactly the bits written as 1. A read returns the status without clearing it.
- R12: A status bit whose event arrives in the same cycle as a clearing access ends that cycle set.
- R13: `irq` is registered. It equals the OR of (status AND enable) as it stood one clock earlier.
- R14: `rdata` shows the value read, one clock after the cycle in which `rd_en` was high. It holds that value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt | input | NCH | Per-channel event inputs that set status bits |
| irq | output | 1 | Interrupt request |

## Verification
An incoming event can meet a clearing access on the status register in the same cycle. This happens under both policies. The bench provokes the collision by raising `evt` in the same clock as a read of 12h, and again in the same clock as a write-one of 12h. In each case a later read must show the event bit still set, while the other bits covered by the access are gone. The bench also checks `irq` on both sides of its one-clock lag when an event or a clear changes the status.

// File: rtl/pbrf_pkg.sv
package pbrf_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int NBANK  = 4;
    localparam int NREG   = (1 << ADDR_W) - 1;

    typedef enum logic [1:0] {
        BK_PRI = 2'd0,
        BK_SEC = 2'd1,
        BK_CHN = 2'd2,
        BK_TST = 2'd3
    } bank_e;

    localparam logic [DATA_W-1:0] SEL_PRI = 8'h00;
    localparam logic [DATA_W-1:0] SEL_SEC = 8'hAA;
    localparam logic [DATA_W-1:0] SEL_CHN = 8'h01;
    localparam logic [DATA_W-1:0] SEL_TST = 8'h02;

    localparam logic [ADDR_W-1:0] A_SEL  = 5'h1F;
    localparam logic [ADDR_W-1:0] A_IEN  = 5'h10;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h12;
    localparam logic [ADDR_W-1:0] A_ICTL = 5'h1E;

    // Which addresses below the selector hold a register in each bank
    function automatic logic slot_used(bank_e b, logic [ADDR_W-1:0] a);
        case (b)
            BK_PRI:  return a <= 5'h15;
            BK_SEC:  return (a <= 5'h06) && (a != 5'h02);
            BK_CHN:  return (a <= 5'h07) || ((a >= 5'h10) && (a <= 5'h16)) || (a == A_ICTL);
            default: return (a == 5'h00) || ((a >= 5'h02) && (a <= 5'h08)) || (a == 5'h10);
        endcase
    endfunction
endpackage

// File: rtl/pbrf_bank_sel.sv
module pbrf_bank_sel
    import pbrf_pkg::*;
(
    input  logic [DATA_W-1:0] sel,
    output bank_e             bank,
    output logic              hit
);
    always_comb begin
        bank = BK_PRI;
        hit  = 1'b1;
        case (sel)
            SEL_PRI: bank = BK_PRI;
            SEL_SEC: bank = BK_SEC;
            SEL_CHN: bank = BK_CHN;
            SEL_TST: bank = BK_TST;
            default: hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbrf_irq_status.sv
module pbrf_irq_status #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] ien,
    output logic [NCH-1:0] status,
    output logic           irq
);
    typedef struct packed {
        logic [NCH-1:0] stat;
        logic           irq;
    } st_t;

    st_t            st_d, st_q;
    logic [NCH-1:0] stat_nx;

    // An event always wins over a clear in the same cycle
    for (genvar i = 0; i < NCH; i++) begin : g_bit
        assign stat_nx[i] = evt[i] | (st_q.stat[i] & ~clr[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = stat_nx;
        st_d.irq  = |(st_q.stat & ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;
    assign irq    = st_q.irq;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import pbrf_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NCH-1:0]    evt,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0]                        sel;
        logic [NBANK-1:0][NREG-1:0][DATA_W-1:0]   mem;
        logic [DATA_W-1:0]                        rdata;
    } regs_t;

    regs_t             r_d, r_q;
    bank_e             bank;
    logic              hit;
    logic [NCH-1:0]    stat_w;
    logic [NCH-1:0]    ien_w;
    logic [NCH-1:0]    clr_w;
    logic              policy_w;
    logic [DATA_W-1:0] sel_w;
    logic              stat_acc;
    logic              in_bank;
    logic [DATA_W-1:0] rd_val;

    pbrf_bank_sel u_sel (
        .sel  (r_q.sel),
        .bank (bank),
        .hit  (hit)
    );

    assign sel_w    = r_q.sel;
    assign ien_w    = r_q.mem[BK_CHN][A_IEN][NCH-1:0];
    assign policy_w = r_q.mem[BK_CHN][A_ICTL][0];
    assign in_bank  = hit && (addr != A_SEL) && slot_used(bank, addr);
    assign stat_acc = in_bank && (bank == BK_CHN) && (addr == A_STAT);

    always_comb begin
        clr_w = '0;
        if (stat_acc) begin
            if (policy_w) clr_w = wr_en ? wdata[NCH-1:0] : '0;
            else          clr_w = rd_en ? '1 : '0;
        end
    end

    pbrf_irq_status #(.NCH(NCH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (clr_w),
        .ien    (ien_w),
        .status (stat_w),
        .irq    (irq)
    );

    always_comb begin
        rd_val = '0;
        if (addr == A_SEL)     rd_val = r_q.sel;
        else if (stat_acc)     rd_val = DATA_W'(stat_w);
        else if (in_bank)      rd_val = r_q.mem[bank][addr];
    end

    always_comb begin
        r_d = r_q;
        if (wr_en && (addr == A_SEL))
            r_d.sel = wdata;
        if (wr_en && in_bank && !stat_acc)
            r_d.mem[bank][addr] = wdata;
        if (rd_en)
            r_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
endmodule

// File: rtl/pbrf_checks.sv
module pbrf_checks
    import pbrf_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NCH-1:0]    evt,
    input logic              irq,
    input logic [DATA_W-1:0] sel,
    input logic [NCH-1:0]    status,
    input logic [NCH-1:0]    ien,
    input logic              policy
);
    logic clr_acc;
    assign clr_acc = (sel == SEL_CHN) && (addr == A_STAT) && (policy ? wr_en : rd_en);

    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEL) |=> (sel == $past(wdata)));

    a_r14_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r12_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    // R9 stickiness; R10 and R11 say only the active-policy access clears
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_acc |=> ((status & $past(status)) == $past(status)));

    a_r13_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(status & ien))));
endmodule

bind banked_regfile pbrf_checks #(.NCH(NCH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .evt    (evt),
    .irq    (irq),
    .sel    (sel_w),
    .status (stat_w),
    .ien    (ien_w),
    .policy (policy_w)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] evt = '0;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic rd_flag = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
    );

    // Monitor: a read issued before a rising edge is judged at the next falling edge
    always @(posedge clk) rd_flag <= rd_en;
    always @(negedge clk) begin
        if (rd_flag && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h expected=%02h", t, rdata, e);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [7:0] e = 8'h00);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; evt = e;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] x, input string t,
                      input logic [7:0] e = 8'h00);
        @(negedge clk);
        exp_q.push_back(x); tag_q.push_back(t);
        rd_en = 1'b1; addr = a; evt = e;
        @(negedge clk);
        rd_en = 1'b0; evt = '0;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk(input logic act, input logic x, input string t);
        n_tests++;
        if (act !== x) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected=%0b", t, act, x);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(irq, 1'b0, "R1 irq low in reset");
        n_tests++;
        if (rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R1: rdata=%02h expected=00", rdata);
        end
        rst_n = 1'b1;
        rd(5'h1F, 8'h00, "R1 selector reset");
        rd(5'h05, 8'h00, "R1 primary reset");

        // R4 primary bank
        wr(5'h00, 8'h11); wr(5'h15, 8'h22); wr(5'h16, 8'h33); wr(5'h1E, 8'h44);
        rd(5'h00, 8'h11, "R4 primary 00");
        rd(5'h15, 8'h22, "R4 primary 15");
        rd(5'h16, 8'h00, "R4 reserved 16");
        rd(5'h1E, 8'h00, "R4 reserved 1E");
        @(negedge clk);
        n_tests++;
        if (rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R14 hold: rdata=%02h expected=00", rdata);
        end

        // R3 and R5 secondary bank
        wr(5'h1F, 8'hAA);
        rd(5'h1F, 8'hAA, "R2 selector in secondary");
        rd(5'h00, 8'h00, "R3 secondary separate from primary");
        wr(5'h00, 8'h55); wr(5'h02, 8'h66); wr(5'h06, 8'h77); wr(5'h07, 8'h88);
        rd(5'h00, 8'h55, "R5 secondary 00");
        rd(5'h02, 8'h00, "R5 secondary gap 02");
        rd(5'h06, 8'h77, "R5 secondary 06");
        rd(5'h07, 8'h00, "R5 secondary unused 07");
        wr(5'h1F, 8'h00);
        rd(5'h00, 8'h11, "R3 primary kept");

        // R8 invalid selector
        wr(5'h1F, 8'h03);
        rd(5'h1F, 8'h03, "R2 selector holds invalid code");
        wr(5'h00, 8'h99);
        rd(5'h00, 8'h00, "R8 invalid bank reads zero");
        wr(5'h1F, 8'h00);
        rd(5'h00, 8'h11, "R8 invalid write ignored");

        // R7 test bank
        wr(5'h1F, 8'h02);
        wr(5'h08, 8'h5A); wr(5'h09, 8'h6B); wr(5'h10, 8'hA5); wr(5'h01, 8'h7C);
        rd(5'h08, 8'h5A, "R7 test 08");
        rd(5'h09, 8'h00, "R7 test unused 09");
        rd(5'h10, 8'hA5, "R7 test 10");
        rd(5'h01, 8'h00, "R7 test unused 01");

        // R6 per-channel bank
        wr(5'h1F, 8'h01);
        wr(5'h07, 8'hC3); wr(5'h17, 8'h3C); wr(5'h08, 8'h0F);
        rd(5'h07, 8'hC3, "R6 channel 07");
        rd(5'h17, 8'h00, "R6 channel unused 17");
        rd(5'h08, 8'h00, "R6 channel unused 08");

        // R9 R10 clear on read
        pulse(8'h05);
        rd(5'h12, 8'h05, "R9 status set by events");
        rd(5'h12, 8'h00, "R10 read cleared status");
        pulse(8'h02);
        wr(5'h12, 8'hFF);
        rd(5'h12, 8'h02, "R10 write has no effect");
        rd(5'h12, 8'h00, "R10 cleared after read");

        // R13 interrupt with enable mask
        wr(5'h10, 8'h04);
        rd(5'h10, 8'h04, "R6 enable register");
        pulse(8'h01);
        @(negedge clk);
        chk(irq, 1'b0, "R13 masked event");
        rd(5'h12, 8'h01, "R10 masked status");
        pulse(8'h04);
        chk(irq, 1'b0, "R13 one clock lag on set");
        @(negedge clk);
        chk(irq, 1'b1, "R13 irq raised");
        rd(5'h12, 8'h04, "R10 enabled status");
        chk(irq, 1'b1, "R13 one clock lag on clear");
        @(negedge clk);
        chk(irq, 1'b0, "R13 irq cleared by read");

        // R11 clear on write
        wr(5'h1E, 8'h01);
        pulse(8'h0C);
        rd(5'h12, 8'h0C, "R11 status visible");
        rd(5'h12, 8'h0C, "R11 read does not clear");
        wr(5'h12, 8'h04);
        rd(5'h12, 8'h08, "R11 write one clears bit");
        @(negedge clk);
        chk(irq, 1'b0, "R13 irq follows write clear");
        wr(5'h12, 8'h08);
        rd(5'h12, 8'h00, "R11 all cleared");

        // R12 collisions under both policies
        pulse(8'h01);
        wr(5'h12, 8'h01, 8'h11);
        rd(5'h12, 8'h11, "R12 event kept over write clear");
        wr(5'h12, 8'h11);
        wr(5'h1E, 8'h00);
        pulse(8'h40);
        rd(5'h12, 8'h40, "R12 old value on colliding read", 8'h60);
        rd(5'h12, 8'h60, "R12 event kept over read clear");
        rd(5'h1F, 8'h01, "R2 selector in channel bank");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule